// File: doc/BRIEF.md
# Masked Bit-Serial SIMD Lane Array

This block is a row of one-bit processing lanes that all carry out the same broadcast instruction on the same clock edge. Every lane has its own small bit memory, a carry/state flip-flop and an activity flag. Each lane has two three-input lookup units, A and B. Their truth tables come from the instruction, and their operand bits come from local memory, from a neighbouring lane or from the lane's carry state. Multi-bit arithmetic is built by the controller as a sequence of bit-serial instructions, least significant bit first. The carry flip-flop links one step to the next.

Data-dependent work is done by predication. The controller loads the activity flags from a lookup result, issues the operation that only the selected lanes should perform, and then re-enables every lane. For a data-dependent branch, each lane supplies one chosen bit, optionally inverted. These bits are combined by a logarithmic OR tree into a single registered status bit. The per-lane bits are also registered and brought out, so the controller can see which lanes raised the flag.

Top module: `simd_array`

## Requirements
- R1: Every lane executes the instruction present on the inputs at a rising clock edge in that same cycle, with no per-lane stall or skew.
- R2: Each lookup unit returns bit {z,y,x} of its 8-bit table (x is bit 0 of the index). x is local memory at `rd_a_i`. y is chosen by `bsrc_i`: 0 = local memory at `rd_b_i`, 1 = left lane's memory at `rd_b_i`, 2 = right lane's memory at `rd_b_i`, 3 = constant 0. z is the lane's carry when `zsel_i`=0 and constant 0 when `zsel_i`=1.
- R3: Each lane has MEM_DEPTH bits of memory. When `op_i`=1 (execute) and `mem_we_i`=1, the result of unit A is written at address `wr_i`. The read addresses are sampled before that write.
- R4: When `op_i`=1 and `carry_we_i`=1, the carry flip-flop takes the result of unit B. No other condition changes the carry, so a carry written in one cycle is the z operand of the next.
- R5: The left neighbour of lane i is lane i-1 and the right neighbour is lane i+1. Lane 0 reads 0 for its left neighbour, and the last lane reads 0 for its right neighbour.
- R6: A lane whose activity flag is clear writes neither memory nor carry.
- R7: When `op_i`=2 (set mask), each active lane loads its activity flag from the result of unit A. Inactive lanes stay inactive, and nothing else is written.
- R8: When `op_i`=3 (mask all), every lane becomes active, including inactive ones, and no memory or carry is written. `op_i`=0 writes nothing.
- R9: On every edge, `lane_o[i]` takes lane i's selected bit, XORed with `or_inv_i`. The selected bit is the unit A result when `or_src_i`=0 and the activity flag when `or_src_i`=1. On the same edge `status_o` takes the OR of all those bits, so it appears one cycle after the instruction.
- R10: Synchronous active-high reset clears all memory, carries, `lane_o` and `status_o`, and makes every lane active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Opcode: 0 nop, 1 execute, 2 set mask, 3 mask all |
| rd_a_i | input | ADDR_W | Memory address of operand x |
| rd_b_i | input | ADDR_W | Memory address for y, local or neighbour |
| wr_i | input | ADDR_W | Memory write address |
| bsrc_i | input | 2 | Source of operand y |
| zsel_i | input | 1 | 0: z is carry, 1: z is 0 |
| lut_a_i | input | 8 | Truth table of unit A |
| lut_b_i | input | 8 | Truth table of unit B |
| mem_we_i | input | 1 | Memory write enable for execute |
| carry_we_i | input | 1 | Carry write enable for execute |
| or_src_i | input | 1 | Status bit source: 0 unit A, 1 activity flag |
| or_inv_i | input | 1 | Invert each lane's status bit before the OR |
| lane_o | output | LANES | Registered per-lane status bits |
| status_o | output | 1 | Registered OR of all lane status bits |

## Verification
The checker looks at every cycle. It confirms that the status bit always equals the OR of the registered lane bits, that no carry flip-flop moves without an execute with carry write enabled, and that an inactive lane's carry holds. It also confirms that set-mask never raises a flag, that mask-all leaves every lane active, and that reset leaves every lane active with quiet outputs. The bench's scenarios cover the rest: the lookup encodings, the memory contents seen through the status outputs, the neighbour shifts with zero fill at both ends, a two-bit bit-serial addition, masked writes, nested masking, and the one-cycle latency of the status bit.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DEF_LANES     = 8;
    localparam int DEF_MEM_DEPTH = 64;

    typedef enum logic [1:0] {
        OP_NOP     = 2'd0,
        OP_EXEC    = 2'd1,
        OP_SETMASK = 2'd2,
        OP_MASKALL = 2'd3
    } simd_op_e;

    typedef enum logic [1:0] {
        BSRC_MEM   = 2'd0,
        BSRC_LEFT  = 2'd1,
        BSRC_RIGHT = 2'd2,
        BSRC_ZERO  = 2'd3
    } bsrc_e;

    // Broadcast control word, address fields excluded (their width is a parameter)
    typedef struct packed {
        simd_op_e   op;
        bsrc_e      bsrc;
        logic       zsel;
        logic [7:0] lut_a;
        logic [7:0] lut_b;
        logic       mem_we;
        logic       carry_we;
        logic       or_src;
        logic       or_inv;
    } simd_ctrl_t;

    // Three-input lookup: index is {z,y,x}
    function automatic logic lut3(input logic [7:0] table_v, input logic x,
                                  input logic y, input logic z);
        return table_v[{z, y, x}];
    endfunction

endpackage

// File: rtl/simd_or_tree.sv
module simd_or_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             any_o
);
    localparam int LVL = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int PAD = 1 << LVL;

    logic [PAD-1:0] padded;

    always_comb begin
        padded = '0;
        padded[WIDTH-1:0] = bits_i;
    end

    // One level per generate block; level l holds PAD>>l partial ORs
    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int W = PAD >> l;
        logic [W-1:0] v;
        if (l == 0) begin : g_leaf
            assign v = padded;
        end else begin : g_node
            for (genvar k = 0; k < W; k++) begin : g_k
                assign v[k] = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
            end
        end
    end

    assign any_o = g_lvl[LVL].v[0];

endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int MEM_DEPTH = DEF_MEM_DEPTH,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  simd_ctrl_t        ctrl,
    input  logic [ADDR_W-1:0] rd_a,
    input  logic [ADDR_W-1:0] rd_b,
    input  logic [ADDR_W-1:0] wr,
    input  logic              left_nb,
    input  logic              right_nb,
    output logic              nb_o,
    output logic              sel_o,
    output logic              mask_o,
    output logic              carry_o
);
    logic [MEM_DEPTH-1:0] mem_q;
    logic                 carry_q;
    logic                 mask_q;

    logic op_x, op_y, op_z;
    logic res_a, res_b;
    logic may_write;

    assign op_x = mem_q[rd_a];
    assign nb_o = mem_q[rd_b];

    always_comb begin
        unique case (ctrl.bsrc)
            BSRC_MEM:   op_y = mem_q[rd_b];
            BSRC_LEFT:  op_y = left_nb;
            BSRC_RIGHT: op_y = right_nb;
            default:    op_y = 1'b0;
        endcase
    end

    assign op_z  = ctrl.zsel ? 1'b0 : carry_q;
    assign res_a = lut3(ctrl.lut_a, op_x, op_y, op_z);
    assign res_b = lut3(ctrl.lut_b, op_x, op_y, op_z);

    assign may_write = mask_q && (ctrl.op == OP_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            carry_q <= 1'b0;
            mask_q  <= 1'b1;
        end else begin
            if (may_write && ctrl.mem_we)
                mem_q[wr] <= res_a;
            if (may_write && ctrl.carry_we)
                carry_q <= res_b;
            if (ctrl.op == OP_MASKALL)
                mask_q <= 1'b1;
            else if (ctrl.op == OP_SETMASK && mask_q)
                mask_q <= res_a;
        end
    end

    assign sel_o   = (ctrl.or_src ? mask_q : res_a) ^ ctrl.or_inv;
    assign mask_o  = mask_q;
    assign carry_o = carry_q;

endmodule

// File: rtl/simd_array.sv
module simd_array
    import simd_pkg::*;
#(
    parameter  int LANES     = DEF_LANES,
    parameter  int MEM_DEPTH = DEF_MEM_DEPTH,
    localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] rd_a_i,
    input  logic [ADDR_W-1:0] rd_b_i,
    input  logic [ADDR_W-1:0] wr_i,
    input  logic [1:0]        bsrc_i,
    input  logic              zsel_i,
    input  logic [7:0]        lut_a_i,
    input  logic [7:0]        lut_b_i,
    input  logic              mem_we_i,
    input  logic              carry_we_i,
    input  logic              or_src_i,
    input  logic              or_inv_i,
    output logic [LANES-1:0]  lane_o,
    output logic              status_o
);
    simd_ctrl_t ctrl;

    logic [LANES-1:0] nb_vec;
    logic [LANES-1:0] sel_vec;
    logic [LANES-1:0] mask_vec;
    logic [LANES-1:0] carry_vec;
    logic             any_sel;
    logic [LANES-1:0] lane_q;
    logic             status_q;

    always_comb begin
        ctrl.op       = simd_op_e'(op_i);
        ctrl.bsrc     = bsrc_e'(bsrc_i);
        ctrl.zsel     = zsel_i;
        ctrl.lut_a    = lut_a_i;
        ctrl.lut_b    = lut_b_i;
        ctrl.mem_we   = mem_we_i;
        ctrl.carry_we = carry_we_i;
        ctrl.or_src   = or_src_i;
        ctrl.or_inv   = or_inv_i;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic lnb, rnb;
        if (i == 0) begin : g_lf
            assign lnb = 1'b0;
        end else begin : g_li
            assign lnb = nb_vec[i-1];
        end
        if (i == LANES - 1) begin : g_rl
            assign rnb = 1'b0;
        end else begin : g_ri
            assign rnb = nb_vec[i+1];
        end

        simd_lane #(
            .MEM_DEPTH(MEM_DEPTH),
            .ADDR_W   (ADDR_W)
        ) lane_i (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl),
            .rd_a    (rd_a_i),
            .rd_b    (rd_b_i),
            .wr      (wr_i),
            .left_nb (lnb),
            .right_nb(rnb),
            .nb_o    (nb_vec[i]),
            .sel_o   (sel_vec[i]),
            .mask_o  (mask_vec[i]),
            .carry_o (carry_vec[i])
        );
    end

    simd_or_tree #(.WIDTH(LANES)) or_tree_i (
        .bits_i(sel_vec),
        .any_o (any_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q   <= '0;
            status_q <= 1'b0;
        end else begin
            lane_q   <= sel_vec;
            status_q <= any_sel;
        end
    end

    assign lane_o   = lane_q;
    assign status_o = status_q;

endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       op_i,
    input logic             carry_we_i,
    input logic [LANES-1:0] mask_vec,
    input logic [LANES-1:0] carry_vec,
    input logic [LANES-1:0] lane_o,
    input logic             status_o
);
    // R9: the status bit is the OR of the registered lane bits
    a_r9_status_is_or: assert property (@(posedge clk) disable iff (rst)
        status_o == (|lane_o));

    // R4: the carry moves only on execute with carry write enabled
    a_r4_carry_only_on_exec: assert property (@(posedge clk) disable iff (rst)
        !(op_i == 2'd1 && carry_we_i) |=> $stable(carry_vec));

    // R6: inactive lanes keep their carry
    a_r6_inactive_carry_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((carry_vec ^ $past(carry_vec)) & ~$past(mask_vec)) == '0);

    // R7: set mask never turns an inactive lane active
    a_r7_setmask_no_raise: assert property (@(posedge clk) disable iff (rst)
        op_i == 2'd2 |=> (mask_vec & ~$past(mask_vec)) == '0);

    // R8: mask all leaves every lane active
    a_r8_maskall_all_active: assert property (@(posedge clk) disable iff (rst)
        op_i == 2'd3 |=> (&mask_vec));

    // R10: right after reset every lane is active and outputs are quiet
    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&mask_vec) && lane_o == '0 && !status_o));

endmodule

bind simd_array simd_array_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .carry_we_i(carry_we_i),
    .mask_vec  (mask_vec),
    .carry_vec (carry_vec),
    .lane_o    (lane_o),
    .status_o  (status_o)
);

// File: tb/simd_array_tb_top.sv
module simd_array_tb_top;

    localparam int LANES = 8;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] FIRST_A = AW'(63);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_i = 2'd0;
    logic [AW-1:0]    rd_a_i = '0, rd_b_i = '0, wr_i = '0;
    logic [1:0]       bsrc_i = 2'd0;
    logic             zsel_i = 1'b0;
    logic [7:0]       lut_a_i = 8'h00, lut_b_i = 8'h00;
    logic             mem_we_i = 1'b0, carry_we_i = 1'b0;
    logic             or_src_i = 1'b0, or_inv_i = 1'b0;
    logic [LANES-1:0] lane_o;
    logic             status_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    simd_array dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .rd_a_i(rd_a_i), .rd_b_i(rd_b_i),
        .wr_i(wr_i), .bsrc_i(bsrc_i), .zsel_i(zsel_i), .lut_a_i(lut_a_i),
        .lut_b_i(lut_b_i), .mem_we_i(mem_we_i), .carry_we_i(carry_we_i),
        .or_src_i(or_src_i), .or_inv_i(or_inv_i), .lane_o(lane_o),
        .status_o(status_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_i = 2'd0; rd_a_i = '0; rd_b_i = '0; wr_i = '0; bsrc_i = 2'd0;
        zsel_i = 1'b0; lut_a_i = 8'h00; lut_b_i = 8'h00; mem_we_i = 1'b0;
        carry_we_i = 1'b0; or_src_i = 1'b0; or_inv_i = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // Execute with a memory write of unit A (and optional carry write of unit B)
    task automatic do_exec(input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic [1:0] bs, input logic zs,
                           input logic [7:0] la, input logic [7:0] lb,
                           input logic [AW-1:0] w, input logic mwe, input logic cwe);
        op_i = 2'd1; rd_a_i = a; rd_b_i = b; bsrc_i = bs; zsel_i = zs;
        lut_a_i = la; lut_b_i = lb; wr_i = w; mem_we_i = mwe; carry_we_i = cwe;
        step();
    endtask

    // Nop that shows memory bit x at address a on lane_o
    task automatic read_mem(input logic [AW-1:0] a, output logic [7:0] v);
        rd_a_i = a; zsel_i = 1'b1; lut_a_i = 8'hAA;
        step();
        v = lane_o;
    endtask

    task automatic read_mask(output logic [7:0] v);
        or_src_i = 1'b1;
        step();
        v = lane_o;
    endtask

    task automatic read_carry(output logic [7:0] v);
        lut_a_i = 8'hF0;
        step();
        v = lane_o;
    endtask

    // Marks lane 0 with a 1 at FIRST_A, all other lanes 0 (needs all lanes active)
    task automatic make_first();
        do_exec('0, '0, 2'd3, 1'b1, 8'hFF, 8'h00, FIRST_A, 1'b1, 1'b0);
        do_exec('0, FIRST_A, 2'd1, 1'b1, 8'hCC, 8'h00, FIRST_A, 1'b1, 1'b0);
        do_exec(FIRST_A, '0, 2'd3, 1'b1, 8'h55, 8'h00, FIRST_A, 1'b1, 1'b0);
    endtask

    // Shift a pattern in from lane 0 (y = left neighbour, x = first marker)
    task automatic load_pat(input logic [AW-1:0] d, input logic [7:0] p);
        for (int s = 0; s < LANES; s++)
            do_exec(FIRST_A, d, 2'd1, 1'b1, p[LANES-1-s] ? 8'hEE : 8'hCC,
                    8'h00, d, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R10 lane_o after reset", lane_o, 8'h00);
        chk("R10 status after reset", {7'd0, status_o}, 8'h00);
        read_mem(AW'(5), v);
        chk("R10 memory cleared", v, 8'h00);
        read_mask(v);
        chk("R10 all lanes active", v, 8'hFF);
        read_carry(v);
        chk("R10 carry cleared", v, 8'h00);
    endtask

    task automatic t_load();
        logic [7:0] v;
        make_first();
        read_mem(FIRST_A, v);
        chk("R5 left edge zero gives lane0 marker", v, 8'h01);
        load_pat(AW'(10), 8'hB4);
        load_pat(AW'(12), 8'h0F);
        read_mem(AW'(10), v);
        chk("R1 R3 pattern B4 read back", v, 8'hB4);
        read_mem(AW'(12), v);
        chk("R3 pattern 0F read back", v, 8'h0F);
    endtask

    task automatic t_neighbour();
        logic [7:0] v;
        rd_b_i = AW'(10); bsrc_i = 2'd1; zsel_i = 1'b1; lut_a_i = 8'hCC;
        step();
        chk("R5 left neighbour shift", lane_o, 8'h68);
        rd_b_i = AW'(10); bsrc_i = 2'd2; zsel_i = 1'b1; lut_a_i = 8'hCC;
        step();
        chk("R5 right neighbour shift, end reads zero", lane_o, 8'h5A);
        rd_a_i = AW'(12); rd_b_i = AW'(10); bsrc_i = 2'd0; zsel_i = 1'b1; lut_a_i = 8'h66;
        step();
        chk("R2 x xor local y", lane_o, 8'hBB);
    endtask

    task automatic t_add();
        logic [7:0] a0, a1, b0, b1, s0, s1, co, v;
        a0 = 8'hF0; a1 = 8'hCC; b0 = 8'hAA; b1 = 8'h0F;
        load_pat(AW'(20), a0); load_pat(AW'(21), a1);
        load_pat(AW'(22), b0); load_pat(AW'(23), b1);
        for (int i = 0; i < LANES; i++) begin
            int sa, sb, sm;
            sa = a0[i] + 2 * a1[i];
            sb = b0[i] + 2 * b1[i];
            sm = sa + sb;
            s0[i] = sm[0]; s1[i] = sm[1]; co[i] = sm[2];
        end
        do_exec('0, '0, 2'd3, 1'b1, 8'h00, 8'h00, '0, 1'b0, 1'b1);
        do_exec(AW'(20), AW'(22), 2'd0, 1'b0, 8'h96, 8'hE8, AW'(24), 1'b1, 1'b1);
        do_exec(AW'(21), AW'(23), 2'd0, 1'b0, 8'h96, 8'hE8, AW'(25), 1'b1, 1'b1);
        read_mem(AW'(24), v);
        chk("R4 sum bit 0", v, s0);
        read_mem(AW'(25), v);
        chk("R4 sum bit 1 uses carry", v, s1);
        read_carry(v);
        chk("R4 carry out", v, co);
    endtask

    task automatic t_mask();
        logic [7:0] v, cprev;
        read_carry(cprev);
        op_i = 2'd2; rd_a_i = AW'(10); zsel_i = 1'b1; lut_a_i = 8'hAA;
        mem_we_i = 1'b1; wr_i = AW'(40);
        step();
        read_mask(v);
        chk("R7 mask loaded from unit A", v, 8'hB4);
        read_mem(AW'(40), v);
        chk("R7 set mask writes no memory", v, 8'h00);
        do_exec('0, '0, 2'd3, 1'b1, 8'hFF, 8'hFF, AW'(30), 1'b1, 1'b1);
        read_mem(AW'(30), v);
        chk("R6 masked memory write", v, 8'hB4);
        read_carry(v);
        chk("R6 masked carry write", v, 8'hB4 | (cprev & ~8'hB4));
        op_i = 2'd2; rd_a_i = AW'(12); zsel_i = 1'b1; lut_a_i = 8'hAA;
        step();
        read_mask(v);
        chk("R7 nested mask keeps inactive lanes off", v, 8'h04);
        op_i = 2'd3; wr_i = AW'(30); mem_we_i = 1'b1; carry_we_i = 1'b1;
        lut_a_i = 8'h00; lut_b_i = 8'h00; zsel_i = 1'b1;
        step();
        read_mask(v);
        chk("R8 mask all", v, 8'hFF);
        read_mem(AW'(30), v);
        chk("R8 mask all writes no memory", v, 8'hB4);
        read_carry(v);
        chk("R8 mask all writes no carry", v, 8'hB4 | (cprev & ~8'hB4));
        op_i = 2'd0; wr_i = AW'(30); mem_we_i = 1'b1; zsel_i = 1'b1; lut_a_i = 8'h00;
        step();
        read_mem(AW'(30), v);
        chk("R8 nop writes no memory", v, 8'hB4);
    endtask

    task automatic t_status();
        logic [7:0] v;
        do_exec('0, '0, 2'd3, 1'b1, 8'hFF, 8'h00, AW'(31), 1'b1, 1'b0);
        read_mem(AW'(5), v);
        chk("R9 status low on all-zero bits", {7'd0, status_o}, 8'h00);
        rd_a_i = AW'(10); zsel_i = 1'b1; lut_a_i = 8'hAA;
        #1;
        chk("R9 status not yet updated before edge", {7'd0, status_o}, 8'h00);
        step();
        chk("R9 status one cycle later", {7'd0, status_o}, 8'h01);
        rd_a_i = AW'(10); zsel_i = 1'b1; lut_a_i = 8'hAA; or_inv_i = 1'b1;
        step();
        chk("R9 inverted lane bits", lane_o, 8'h4B);
        rd_a_i = AW'(31); zsel_i = 1'b1; lut_a_i = 8'hAA; or_inv_i = 1'b1;
        step();
        chk("R9 inverted all-ones gives status low", {7'd0, status_o}, 8'h00);
        rd_a_i = AW'(12); zsel_i = 1'b1; lut_a_i = 8'hAA; or_src_i = 1'b1; or_inv_i = 1'b1;
        step();
        chk("R9 mask source inverted, all active", {7'd0, status_o}, 8'h00);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_neighbour();
        t_add();
        t_mask();
        t_status();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule